// File: doc/BRIEF.md
# Sparsified Pixel Hit and Time Stamp Readout

This block is the digital half of a pixel detector readout, reduced to a small square array. During an acquisition window each pixel watches its binary discriminator input and its test-injection input. The first hit of the window sets the pixel's hit flag, and the pixel also captures the 5-bit Gray-coded time stamp that a shared counter in the periphery drives to every pixel. The flag and the stamp stay in the pixel until the next window begins.

Once the window is closed, a readout pulse starts a token through the array in row-major order. The token stops only at pixels that hold a hit. It skips empty pixels in the same clock, so frames follow one another with no gap. Each visited pixel sends one frame, MSB first, on a single serial line: a start bit, the row, the column and the time stamp, with a frame-valid strobe. A read pixel loses its hit flag. A universal-read option makes the token visit every pixel, hit or not.

Top module: `pixel_readout_array`

## Requirements
- R1: After reset `ser_o`, `frame_o` and `rd_done_o` are all 0.
- R2: A pixel hit on the k-th acquisition cycle after `win_start` (k = 1, 2, ...) captures the Gray code `g = n ^ (n >> 1)` with n = min(k-1, 31). The shared counter saturates at Gray 31 (5'b10000) and changes at most one bit per cycle.
- R3: Only the first hit of a window captures a time stamp. Later hits on the same pixel in that window leave the stored stamp unchanged.
- R4: A pulse on a pixel's `test_i` bit has the same effect as a pulse on its `hit_i` bit.
- R5: Hit and test inputs have no effect while `acq_en` is 0.
- R6: A frame is FRAME = 1 + 2*AW + 5 bits long, with AW = log2(SIDE). The bits are sent MSB first in this order: start bit 1, row (AW bits), column (AW bits), time stamp (5 bits). Pixel index = row*SIDE + column. `frame_o` is 1 for every bit of a frame. Bit 0 appears in the cycle after the clock edge that samples `rd_start`.
- R7: In sparse mode only pixels with a hit send frames, in ascending index order. The next frame's start bit follows the cycle after the previous frame's last bit.
- R8: `rd_done_o` rises in the cycle after the last frame's last bit, or in the cycle after `rd_start` when nothing is pending. It stays high with `frame_o` low until `win_start` or a new `rd_start`.
- R9: `rd_start` is ignored while `acq_en` is 1.
- R10: With `univ_rd` high at `rd_start`, all SIDE*SIDE pixels send frames in index order. Pixels without a hit report time stamp 0.
- R11: A read pixel's hit flag is cleared, so a second sparse readout of the same window sends no frames.
- R12: `win_start` clears every hit flag and time stamp and sets the counter back to Gray 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_start | input | 1 | Clears pixels and counter at the start of a window |
| acq_en | input | 1 | High while the acquisition window is open |
| hit_i | input | SIDE*SIDE | Discriminator hits, one per pixel |
| test_i | input | SIDE*SIDE | Test-injection hits, one per pixel |
| rd_start | input | 1 | Starts a token readout pass |
| univ_rd | input | 1 | Read all pixels when sampled with `rd_start` |
| ser_o | output | 1 | Serial data line |
| frame_o | output | 1 | High during each frame bit |
| rd_done_o | output | 1 | Readout pass finished |

## Verification
A sweep sends a single hit through each pixel in turn, at a cycle that varies with the index. This shows that row and column decoding and the time-stamp capture line up for every position. Windows longer than 32 cycles separate a saturating counter from a wrapping one. Repeated hits on a pixel tell first-hit capture apart from last-hit capture. Hits made only through the test input, hits made with the window closed, and a universal read over mostly empty pixels tell real flags apart from forced visits. A second readout of the same window and a readout after `win_start` show whether flags are cleared.

// File: rtl/pra_pkg.sv
package pra_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_DONE  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pra_gray_counter.sv
module pra_gray_counter #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    output logic [TS_W-1:0] gray_o
);
    localparam logic [TS_W-1:0] LAST = {TS_W{1'b1}};

    typedef struct packed {
        logic [TS_W-1:0] bin;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d.bin = '0;
        end else if (en && cnt_q.bin != LAST) begin
            cnt_d.bin = cnt_q.bin + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign gray_o = cnt_q.bin ^ (cnt_q.bin >> 1);
endmodule

// File: rtl/pra_pixel.sv
module pra_pixel #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_clr,
    input  logic            acq_en,
    input  logic            hit_i,
    input  logic            test_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic            rd_clr,
    output logic            hit_o,
    output logic [TS_W-1:0] ts_o
);
    typedef struct packed {
        logic            hit;
        logic [TS_W-1:0] ts;
    } pix_t;

    pix_t pix_d, pix_q;

    always_comb begin
        pix_d = pix_q;
        if (win_clr) begin
            pix_d = '0;
        end else begin
            if (acq_en && (hit_i || test_i) && !pix_q.hit) begin
                pix_d.hit = 1'b1;
                pix_d.ts  = ts_i;
            end
            if (rd_clr) pix_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign hit_o = pix_q.hit;
    assign ts_o  = pix_q.ts;
endmodule

// File: rtl/pra_token_scan.sv
module pra_token_scan #(
    parameter int NPIX = 16,
    parameter int IDXW = 4
) (
    input  logic [NPIX-1:0] pend_i,
    input  logic [IDXW:0]   base_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NPIX - 1; i >= 0; i--) begin
            if (pend_i[i] && (int'(base_i) <= i)) begin
                found_o = 1'b1;
                idx_o   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/pixel_readout_array.sv
module pixel_readout_array #(
    parameter int SIDE = 4,
    parameter int TS_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_start,
    input  logic                 acq_en,
    input  logic [SIDE*SIDE-1:0] hit_i,
    input  logic [SIDE*SIDE-1:0] test_i,
    input  logic                 rd_start,
    input  logic                 univ_rd,
    output logic                 ser_o,
    output logic                 frame_o,
    output logic                 rd_done_o
);
    import pra_pkg::*;

    localparam int NPIX  = SIDE * SIDE;
    localparam int AW    = (SIDE > 1) ? $clog2(SIDE) : 1;
    localparam int IDXW  = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int FRAME = 1 + 2 * AW + TS_W;
    localparam int BW    = $clog2(FRAME);

    typedef struct packed {
        rd_state_e       st;
        logic            univ;
        logic [IDXW-1:0] idx;
        logic [BW-1:0]   bitn;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [TS_W-1:0] ts_gray;
    logic [NPIX-1:0] hit_vec;
    logic [TS_W-1:0] ts_arr [NPIX];
    logic [NPIX-1:0] rd_clr_vec;
    logic [NPIX-1:0] pend;
    logic [IDXW:0]   scan_base;
    logic            scan_found;
    logic [IDXW-1:0] scan_idx;
    logic            last_bit;
    logic [FRAME-1:0] word;
    logic [FRAME-1:0] word_sh;
    logic [AW-1:0]   row_sel;
    logic [AW-1:0]   col_sel;

    pra_gray_counter #(.TS_W(TS_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_start),
        .en     (acq_en),
        .gray_o (ts_gray)
    );

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pra_pixel #(.TS_W(TS_W)) u_pix (
            .clk     (clk),
            .rst_n   (rst_n),
            .win_clr (win_start),
            .acq_en  (acq_en),
            .hit_i   (hit_i[p]),
            .test_i  (test_i[p]),
            .ts_i    (ts_gray),
            .rd_clr  (rd_clr_vec[p]),
            .hit_o   (hit_vec[p]),
            .ts_o    (ts_arr[p])
        );
    end

    assign last_bit = (rd_q.st == RD_SHIFT) && (rd_q.bitn == BW'(FRAME - 1));

    always_comb begin
        rd_clr_vec = '0;
        if (last_bit) rd_clr_vec[rd_q.idx] = 1'b1;
    end

    always_comb begin
        if (rd_q.st == RD_SHIFT) begin
            pend      = hit_vec | {NPIX{rd_q.univ}};
            scan_base = {1'b0, rd_q.idx} + 1'b1;
        end else begin
            pend      = hit_vec | {NPIX{univ_rd}};
            scan_base = '0;
        end
    end

    pra_token_scan #(.NPIX(NPIX), .IDXW(IDXW)) u_scan (
        .pend_i  (pend),
        .base_i  (scan_base),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    always_comb begin
        rd_d = rd_q;
        case (rd_q.st)
            RD_SHIFT: begin
                if (last_bit) begin
                    if (scan_found) begin
                        rd_d.idx  = scan_idx;
                        rd_d.bitn = '0;
                    end else begin
                        rd_d.st = RD_DONE;
                    end
                end else begin
                    rd_d.bitn = rd_q.bitn + 1'b1;
                end
            end
            default: begin
                if (win_start) begin
                    rd_d.st = RD_IDLE;
                end else if (rd_start && !acq_en) begin
                    rd_d.univ = univ_rd;
                    rd_d.bitn = '0;
                    if (scan_found) begin
                        rd_d.st  = RD_SHIFT;
                        rd_d.idx = scan_idx;
                    end else begin
                        rd_d.st = RD_DONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.st   <= RD_IDLE;
            rd_q.univ <= 1'b0;
            rd_q.idx  <= '0;
            rd_q.bitn <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        row_sel = AW'(int'(rd_q.idx) / SIDE);
        col_sel = AW'(int'(rd_q.idx) % SIDE);
        word    = {1'b1, row_sel, col_sel, ts_arr[rd_q.idx]};
        word_sh = word << rd_q.bitn;
    end

    assign frame_o   = (rd_q.st == RD_SHIFT);
    assign ser_o     = frame_o & word_sh[FRAME-1];
    assign rd_done_o = (rd_q.st == RD_DONE);
endmodule

// File: rtl/pra_checker.sv
module pra_checker #(
    parameter int TS_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            win_start,
    input logic            acq_en,
    input logic            ser_o,
    input logic            frame_o,
    input logic            rd_done_o,
    input logic [TS_W-1:0] ts_gray
);
    localparam logic [TS_W-1:0] GRAY_TOP = {1'b1, {(TS_W-1){1'b0}}};

    // R2
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_start) || $countones(ts_gray ^ $past(ts_gray)) <= 1));

    // R2
    gray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ts_gray) == GRAY_TOP && !$past(win_start)) |-> ts_gray == GRAY_TOP);

    // R6
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> ser_o);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |-> !frame_o);

    // R8
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> rd_done_o);

    // R9
    no_rd_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_en && !frame_o) |=> !frame_o);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_o |-> !ser_o);
endmodule

bind pixel_readout_array pra_checker #(.TS_W(TS_W)) u_pra_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_start (win_start),
    .acq_en    (acq_en),
    .ser_o     (ser_o),
    .frame_o   (frame_o),
    .rd_done_o (rd_done_o),
    .ts_gray   (ts_gray)
);

// File: tb/pixel_readout_array_bench.sv
`timescale 1ns/1ps
module pixel_readout_array_bench;
    localparam int SIDE  = 4;
    localparam int TS_W  = 5;
    localparam int NPIX  = SIDE * SIDE;
    localparam int AW    = 2;
    localparam int FRAME = 1 + 2 * AW + TS_W;

    logic clk = 1'b0;
    logic rst_n, win_start, acq_en, rd_start, univ_rd;
    logic [NPIX-1:0] hit_i, test_i;
    logic ser_o, frame_o, rd_done_o;

    int checks = 0;
    int failures = 0;
    int exp_hit [NPIX];
    int exp_ts  [NPIX];
    int cnt_m;

    always #4 clk = ~clk;

    pixel_readout_array #(.SIDE(SIDE), .TS_W(TS_W)) u_pixel_readout_array (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .acq_en(acq_en),
        .hit_i(hit_i), .test_i(test_i), .rd_start(rd_start), .univ_rd(univ_rd),
        .ser_o(ser_o), .frame_o(frame_o), .rd_done_o(rd_done_o)
    );

    function automatic int gray(input int n);
        return n ^ (n >> 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic new_window();
        win_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        win_start = 1'b0;
        for (int i = 0; i < NPIX; i++) begin
            exp_hit[i] = 0;
            exp_ts[i]  = 0;
        end
        cnt_m = 0;
    endtask

    task automatic acq_cycle(input logic [NPIX-1:0] h, input logic [NPIX-1:0] t);
        acq_en = 1'b1;
        hit_i  = h;
        test_i = t;
        @(posedge clk);
        for (int i = 0; i < NPIX; i++) begin
            if ((h[i] || t[i]) && exp_hit[i] == 0) begin
                exp_hit[i] = 1;
                exp_ts[i]  = gray(cnt_m);
            end
        end
        if (cnt_m < 31) cnt_m++;
        @(negedge clk);
        hit_i  = '0;
        test_i = '0;
    endtask

    task automatic close_window();
        acq_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic readout(input logic univ, input string req);
        int word;
        int expw;
        int fr_ok;
        rd_start = 1'b1;
        univ_rd  = univ;
        @(posedge clk);
        @(negedge clk);
        rd_start = 1'b0;
        univ_rd  = 1'b0;
        for (int p = 0; p < NPIX; p++) begin
            if (exp_hit[p] != 0 || univ) begin
                word  = 0;
                fr_ok = 1;
                for (int b = 0; b < FRAME; b++) begin
                    if (!frame_o) fr_ok = 0;
                    word = (word << 1) | int'(ser_o);
                    @(posedge clk);
                    @(negedge clk);
                end
                expw = (1 << (FRAME - 1)) | ((p / SIDE) << (AW + TS_W))
                     | ((p % SIDE) << TS_W) | exp_ts[p];
                check({req, " R6 R7 frame word"}, word, expw);
                check({req, " R6 frame strobe"}, fr_ok, 1);
                exp_hit[p] = 0;
            end
        end
        check({req, " R8 done after pass"}, int'(rd_done_o), 1);
        check({req, " R8 strobe low at end"}, int'(frame_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; win_start = 1'b0; acq_en = 1'b0;
        rd_start = 1'b0; univ_rd = 1'b0; hit_i = '0; test_i = '0;
        cnt_m = 0;
        for (int i = 0; i < NPIX; i++) begin
            exp_hit[i] = 0;
            exp_ts[i]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ser", int'(ser_o), 0);
        check("R1 frame", int'(frame_o), 0);
        check("R1 done", int'(rd_done_o), 0);

        // Window A: closed-window hit, repeats, test input, saturation
        new_window();
        hit_i = 16'hFFFF;               // R5 ignored while acq_en low
        @(posedge clk);
        @(negedge clk);
        hit_i = '0;
        for (int k = 1; k <= 40; k++) begin
            logic [NPIX-1:0] h;
            logic [NPIX-1:0] t;
            h = '0;
            t = '0;
            if (k == 1)  h[2]  = 1'b1;  // R2 first cycle -> gray 0
            if (k == 4)  h[5]  = 1'b1;  // R3 first hit
            if (k == 9)  h[5]  = 1'b1;  // R3 later hit ignored
            if (k == 6)  t[7]  = 1'b1;  // R4 test input
            if (k == 20) begin
                h[10] = 1'b1;           // R4 both together
                t[10] = 1'b1;
            end
            if (k == 33) h[15] = 1'b1;  // R2 saturated
            if (k == 40) t[0]  = 1'b1;  // R2 still saturated
            acq_cycle(h, t);
            if (k == 12) begin          // R9 readout request inside window
                rd_start = 1'b1;
                @(posedge clk);
                @(negedge clk);
                rd_start = 1'b0;
                check("R9 no frame in window", int'(frame_o), 0);
                check("R9 no done in window", int'(rd_done_o), 0);
                if (cnt_m < 31) cnt_m++;
            end
        end
        close_window();
        check("R2 model ts of pixel 15", exp_ts[15], 16);
        readout(1'b0, "A sparse");
        readout(1'b0, "R11 second pass");

        // Window B: universal read
        new_window();
        acq_cycle(16'h0000, 16'h0000);
        acq_cycle(16'h0000, 16'h0000);
        acq_cycle(16'h0100, 16'h0000);
        close_window();
        readout(1'b1, "R10 universal");

        // R12: clearing by win_start
        new_window();
        for (int k = 0; k < 8; k++) acq_cycle(16'h0000, 16'h0000);
        acq_cycle(16'h0008, 16'h0000);
        close_window();
        new_window();
        acq_cycle(16'h0020, 16'h0000);
        close_window();
        readout(1'b0, "R12 after clear");

        // Sweep: one pixel per window at a varying cycle
        for (int p = 0; p < NPIX; p++) begin
            new_window();
            for (int k = 0; k < (p * 3) % 37; k++) acq_cycle(16'h0000, 16'h0000);
            acq_cycle(NPIX'(1) << p, 16'h0000);
            close_window();
            readout(1'b0, "R2 R7 sweep");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule